// File: doc/BRIEF.md
# Ingress Admission Stage with Zoned Early Drop and Byte Rate Policer

This block decides, frame by frame, whether traffic arriving on one ingress port may enter the device. Each frame is presented for one cycle along with its traffic class, its length in bytes and the current occupancy of the ingress buffer. There are four classes: managed, unmanaged, reserved and discard. Frames in the discard class are rejected at once. The other frames go through a zoned random early drop. The occupancy selects one of four zones. Each zone has a programmable threshold and an 8-bit drop fraction, and a pseudo-random sample sets the outcome.

A frame that survives early drop is checked against a byte token bucket that limits the port's rate. A programmable timer tick adds a fixed number of bytes to the bucket, up to a burst cap. A frame is admitted only when the bucket holds enough tokens for its whole length. The tick period and the byte increment are chosen to set rates from tens of kbit/s to a few Gbit/s. The stage reports a verdict one cycle after each frame. It also keeps a separate saturating drop count for each rejecting stage.

Top module: `ingress_admit`

## Requirements
- R1: After reset, verdict_valid_o is low, all three drop counters read zero, and the token bucket is empty, so a frame of non-zero length offered before any tick is rejected by the rate stage.
- R2: A frame with class code 3 (discard) is rejected with drop stage code 1. It consumes no tokens and is never counted by the early-drop or rate stages.
- R3: The zone of a frame is the number of thresholds k (0..3, from zone_thr_i[k*16 +: 16]) for which the fill level is greater than or equal to the threshold. Zone 0 never causes an early drop.
- R4: In zone z ≥ 1, let p be zone_prob_i[(z-1)*8 +: 8]. An unmanaged frame (class code 1) is dropped when the 16-bit random sample is less than p·256. A managed frame (class code 0) uses p>>1 instead of p. The resulting drop stage code is 2.
- R5: A reserved frame (class code 2) is never dropped by the early-drop stage.
- R6: The random sample comes from a 16-bit shift register, seeded 16'hACE1 by reset, that shifts left every clock with new bit0 = bit15^bit13^bit12^bit10. A frame uses the value held before the edge that samples it.
- R7: A frame that passes early drop is admitted when the token count is at least its length. The length is then subtracted. Otherwise the frame is rejected with drop stage code 3 and the token count is left as it is.
- R8: On a cycle with tick_i high, refill_bytes_i is added after any subtraction made in that same cycle, and the sum is clamped to burst_cap_i. The admission test in that cycle uses the token count from before the refill.
- R9: Each drop counter increments by one for each frame rejected by its stage, and holds at its all-ones value.
- R10: verdict_valid_o is high exactly one cycle after frame_valid_i. accept_o is high only when the verdict is valid and the drop stage code is 0 (pass).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Refill timer tick |
| refill_bytes_i | input | TOK_W | Bytes added per tick |
| burst_cap_i | input | TOK_W | Maximum token count |
| zone_thr_i | input | ZONES*FILL_W | Zone thresholds, ascending, zone k in slice k |
| zone_prob_i | input | ZONES*PROB_W | Drop fraction per zone, slice k for zone k+1 |
| frame_valid_i | input | 1 | Frame presented this cycle |
| frame_class_i | input | 2 | 0 managed, 1 unmanaged, 2 reserved, 3 discard |
| frame_len_i | input | LEN_W | Frame length in bytes |
| fill_level_i | input | FILL_W | Ingress buffer occupancy |
| verdict_valid_o | output | 1 | Verdict for previous cycle's frame |
| accept_o | output | 1 | Frame admitted |
| drop_stage_o | output | 2 | 0 pass, 1 discard, 2 early drop, 3 rate |
| discard_cnt_o | output | CNT_W | Discard-class drops |
| wred_cnt_o | output | CNT_W | Early-drop rejections |
| rate_cnt_o | output | CNT_W | Rate-stage rejections |

## Verification
Two things can land on the same edge: a timer refill and a frame that checks and consumes tokens. The bench drives ticks together with frames whose length lies between the pre-refill and post-refill token counts, and with frames that empty the bucket exactly. A behavioural model follows the order in R8, so a frame must be rejected when it fits only after the refill, and the clamp must apply after the subtraction. A long randomised phase mixes ticks, classes and fill levels. On every clock the model compares the verdict, the drop stage and all three counters.

// File: rtl/ingress_admit_pkg.sv
package ingress_admit_pkg;
  typedef enum logic [1:0] {
    CLS_MANAGED   = 2'd0,
    CLS_UNMANAGED = 2'd1,
    CLS_RESERVED  = 2'd2,
    CLS_DISCARD   = 2'd3
  } frame_class_e;

  typedef enum logic [1:0] {
    STG_PASS    = 2'd0,
    STG_DISCARD = 2'd1,
    STG_WRED    = 2'd2,
    STG_RATE    = 2'd3
  } drop_stage_e;

  localparam int unsigned NUM_STAGE_CNT = 3;
endpackage

// File: rtl/admit_lfsr.sv
module admit_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] rnd_o
);
  logic [15:0] lfsr_q;
  logic        fb;

  assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[14:0], fb};
  end

  assign rnd_o = lfsr_q;

  // R6: register never locks up at zero
  assert_lfsr_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != 16'd0);
endmodule

// File: rtl/wred_zone_drop.sv
module wred_zone_drop
  import ingress_admit_pkg::*;
#(
  parameter int unsigned ZONES  = 4,
  parameter int unsigned FILL_W = 16,
  parameter int unsigned PROB_W = 8,
  parameter int unsigned RND_W  = 16
) (
  input  logic [FILL_W-1:0]       fill_i,
  input  frame_class_e            class_i,
  input  logic [ZONES*FILL_W-1:0] thr_i,
  input  logic [ZONES*PROB_W-1:0] prob_i,
  input  logic [RND_W-1:0]        rnd_i,
  output logic                    drop_o
);
  localparam int unsigned ZONE_W = $clog2(ZONES + 1);

  logic [ZONE_W-1:0] zone;
  logic [PROB_W-1:0] prob_sel;
  logic [PROB_W-1:0] prob_eff;
  logic [RND_W-1:0]  cut;

  always_comb begin
    zone = '0;
    for (int k = 0; k < ZONES; k++)
      if (fill_i >= thr_i[k*FILL_W +: FILL_W]) zone = zone + 1'b1;
  end

  always_comb begin
    prob_sel = '0;
    for (int k = 0; k < ZONES; k++)
      if (zone == ZONE_W'(k + 1)) prob_sel = prob_i[k*PROB_W +: PROB_W];
  end

  // managed traffic sees half the zone fraction
  assign prob_eff = (class_i == CLS_MANAGED) ? (prob_sel >> 1) : prob_sel;
  assign cut      = {prob_eff, {(RND_W-PROB_W){1'b0}}};

  assign drop_o = (zone != '0)
               && (class_i == CLS_MANAGED || class_i == CLS_UNMANAGED)
               && (rnd_i < cut);
endmodule

// File: rtl/byte_token_bucket.sv
module byte_token_bucket #(
  parameter int unsigned TOK_W = 24,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [TOK_W-1:0] refill_i,
  input  logic [TOK_W-1:0] cap_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             grant_o
);
  logic [TOK_W-1:0] tokens_q, tokens_d, base, len_ext;
  logic [TOK_W:0]   sum;
  logic             take;

  assign len_ext = TOK_W'(len_i);
  assign grant_o = tokens_q >= len_ext;
  assign take    = req_i && grant_o;

  always_comb begin
    base = take ? tokens_q - len_ext : tokens_q;
    sum  = {1'b0, base} + {1'b0, refill_i};
    if (tick_i) tokens_d = (sum > {1'b0, cap_i}) ? cap_i : sum[TOK_W-1:0];
    else        tokens_d = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tokens_q <= '0;
    else         tokens_q <= tokens_d;
  end

  assert_cap_after_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> tokens_q <= $past(cap_i));
  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !take) |=> $stable(tokens_q));
  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !tick_i) |=> tokens_q <= $past(tokens_q));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && ~&cnt_q)      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_mono_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q >= $past(cnt_q));
  assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/ingress_admit.sv
module ingress_admit
  import ingress_admit_pkg::*;
#(
  parameter int unsigned ZONES  = 4,
  parameter int unsigned FILL_W = 16,
  parameter int unsigned PROB_W = 8,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned TOK_W  = 24,
  parameter int unsigned CNT_W  = 32,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [TOK_W-1:0]        refill_bytes_i,
  input  logic [TOK_W-1:0]        burst_cap_i,
  input  logic [ZONES*FILL_W-1:0] zone_thr_i,
  input  logic [ZONES*PROB_W-1:0] zone_prob_i,
  input  logic                    frame_valid_i,
  input  logic [1:0]              frame_class_i,
  input  logic [LEN_W-1:0]        frame_len_i,
  input  logic [FILL_W-1:0]       fill_level_i,
  output logic                    verdict_valid_o,
  output logic                    accept_o,
  output logic [1:0]              drop_stage_o,
  output logic [CNT_W-1:0]        discard_cnt_o,
  output logic [CNT_W-1:0]        wred_cnt_o,
  output logic [CNT_W-1:0]        rate_cnt_o
);
  localparam int unsigned RND_W = 16;

  frame_class_e cls;
  logic [RND_W-1:0] rnd;
  logic wred_drop, grant, is_discard;
  drop_stage_e stage_d, stage_q;
  logic verdict_q;
  logic [NUM_STAGE_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt [NUM_STAGE_CNT];

  assign cls        = frame_class_e'(frame_class_i);
  assign is_discard = (cls == CLS_DISCARD);

  admit_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .rnd_o(rnd)
  );

  wred_zone_drop #(
    .ZONES(ZONES), .FILL_W(FILL_W), .PROB_W(PROB_W), .RND_W(RND_W)
  ) u_wred (
    .fill_i(fill_level_i), .class_i(cls), .thr_i(zone_thr_i),
    .prob_i(zone_prob_i), .rnd_i(rnd), .drop_o(wred_drop)
  );

  byte_token_bucket #(.TOK_W(TOK_W), .LEN_W(LEN_W)) u_bucket (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .refill_i(refill_bytes_i), .cap_i(burst_cap_i),
    .req_i(frame_valid_i && !is_discard && !wred_drop),
    .len_i(frame_len_i), .grant_o(grant)
  );

  always_comb begin
    if (is_discard)  stage_d = STG_DISCARD;
    else if (wred_drop) stage_d = STG_WRED;
    else if (!grant) stage_d = STG_RATE;
    else             stage_d = STG_PASS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_q <= 1'b0;
      stage_q   <= STG_PASS;
    end else begin
      verdict_q <= frame_valid_i;
      if (frame_valid_i) stage_q <= stage_d;
    end
  end

  assign inc[0] = frame_valid_i && (stage_d == STG_DISCARD);
  assign inc[1] = frame_valid_i && (stage_d == STG_WRED);
  assign inc[2] = frame_valid_i && (stage_d == STG_RATE);

  for (genvar s = 0; s < NUM_STAGE_CNT; s++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc[s]), .cnt_o(cnt[s])
    );
  end

  assign verdict_valid_o = verdict_q;
  assign drop_stage_o    = stage_q;
  assign accept_o        = verdict_q && (stage_q == STG_PASS);
  assign discard_cnt_o   = cnt[0];
  assign wred_cnt_o      = cnt[1];
  assign rate_cnt_o      = cnt[2];

  assert_discard_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && frame_class_i == 2'd3) |=> drop_stage_o == 2'd1);
  assert_discard_cnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && frame_class_i == 2'd3) |=> ($stable(wred_cnt_o) && $stable(rate_cnt_o)));
  assert_zone0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && fill_level_i < zone_thr_i[FILL_W-1:0]) |=> drop_stage_o != 2'd2);
  assert_reserved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && frame_class_i == 2'd2) |=> drop_stage_o != 2'd2);
  assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> verdict_valid_o);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !verdict_valid_o);
  assert_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (verdict_valid_o && drop_stage_o == 2'd0));
endmodule

// File: tb/ingress_admit_bench.sv
`timescale 1ns/100ps
module ingress_admit_bench;
  localparam int CNT_W = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic [23:0] refill = '0, cap = '0;
  logic [63:0] thr;
  logic [31:0] prob;
  logic fv = 1'b0;
  logic [1:0] fcls = '0;
  logic [15:0] flen = '0, fill = '0;
  logic vv, acc;
  logic [1:0] stg;
  logic [CNT_W-1:0] c_dis, c_wred, c_rate;

  always #2.5 clk = ~clk;

  ingress_admit #(.CNT_W(CNT_W)) u_ingress_admit (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .refill_bytes_i(refill),
    .burst_cap_i(cap), .zone_thr_i(thr), .zone_prob_i(prob),
    .frame_valid_i(fv), .frame_class_i(fcls), .frame_len_i(flen),
    .fill_level_i(fill), .verdict_valid_o(vv), .accept_o(acc),
    .drop_stage_o(stg), .discard_cnt_o(c_dis), .wred_cnt_o(c_wred),
    .rate_cnt_o(c_rate)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural reference state
  int m_lfsr = 16'hACE1;
  longint m_tok = 0;
  int m_cnt[3] = '{0, 0, 0};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_wred(input int c, input int f);
    int zone = 0;
    int p;
    for (int k = 0; k < 4; k++) if (f >= int'(thr[k*16 +: 16])) zone++;
    if (zone == 0 || c == 2 || c == 3) return 0;
    p = int'(prob[(zone-1)*8 +: 8]);
    if (c == 0) p = p / 2;
    return (m_lfsr < p * 256) ? 1 : 0;
  endfunction

  task automatic step(input bit v, input int c, input int len, input int f,
                      input bit tk, input string tag);
    int e_stg;
    bit b15, b13, b12, b10;
    fv = v; fcls = 2'(c); flen = 16'(len); fill = 16'(f); tick = tk;
    e_stg = 0;
    if (v) begin
      if (c == 3) e_stg = 1;
      else if (model_wred(c, f) != 0) e_stg = 2;
      else if (m_tok >= len) begin e_stg = 0; m_tok -= len; end
      else e_stg = 3;
      if (e_stg != 0 && m_cnt[e_stg-1] < CNT_MAX) m_cnt[e_stg-1]++;
    end
    if (tk) begin
      m_tok += refill;
      if (m_tok > cap) m_tok = cap;
    end
    b15 = m_lfsr[15]; b13 = m_lfsr[13]; b12 = m_lfsr[12]; b10 = m_lfsr[10];
    m_lfsr = ((m_lfsr << 1) & 16'hFFFF) | int'(b15 ^ b13 ^ b12 ^ b10);
    @(posedge clk);
    #1;
    fv = 1'b0; tick = 1'b0;
    chk(vv == v, "R10 verdict_valid", vv, v);
    if (v) begin
      chk(stg == 2'(e_stg), tag, stg, e_stg);
      chk(acc == (e_stg == 0), "R10 accept", acc, e_stg == 0);
    end
    chk(c_dis == CNT_W'(m_cnt[0]), "R9 discard_cnt", c_dis, m_cnt[0]);
    chk(c_wred == CNT_W'(m_cnt[1]), "R9 wred_cnt", c_wred, m_cnt[1]);
    chk(c_rate == CNT_W'(m_cnt[2]), "R9 rate_cnt", c_rate, m_cnt[2]);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    thr  = {16'd400, 16'd300, 16'd200, 16'd100};
    prob = {8'hFF, 8'hA0, 8'h60, 8'h20};
    refill = 24'd100; cap = 24'd300;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(vv == 0, "R1 verdict_valid", vv, 0);
    chk(c_dis == 0 && c_wred == 0 && c_rate == 0, "R1 counters", c_dis + c_wred + c_rate, 0);
    rst_ni = 1'b1;
    // R1 empty bucket rejects
    step(1, 0, 64, 0, 0, "R1 empty bucket");
    // R8 fill to cap
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R8 refill");
    step(1, 1, 300, 0, 0, "R7 exact fit");
    step(1, 1, 1, 0, 0, "R7 empty");
    // R8 refill and frame on the same edge
    step(1, 0, 50, 0, 1, "R8 pre-refill test");
    step(1, 0, 100, 0, 1, "R8 drain with refill");
    step(1, 2, 100, 0, 0, "R7 consume");
    step(1, 2, 1, 0, 0, "R7 after drain");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, "R8 clamp");
    step(1, 1, 301, 0, 0, "R8 clamp at cap");
    // R2 discard leaves tokens
    step(1, 3, 10, 500, 0, "R2 discard");
    step(1, 2, 300, 0, 0, "R2 tokens untouched");
    // R3/R4/R5 zone scans
    for (int i = 0; i < 40; i++) begin
      step(1, i % 3, 1, 99, 1, "R3 zone0");
      step(1, 1, 1, 100 + 100 * (i % 4), 1, "R4 unmanaged");
      step(1, 0, 1, 100 + 100 * (i % 4), 1, "R4 managed");
      step(1, 2, 1, 65535, 1, "R5 reserved");
    end
    // R9 saturation of discard counter
    for (int i = 0; i < 20; i++) step(1, 3, 5, 0, 0, "R9 saturate");
    // random mix, R6 sequence checked through decisions
    refill = 24'd150; cap = 24'd1000;
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(1, 200),
           $urandom_range(0, 500), $urandom_range(0, 1) == 1, "R6 random mix");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule